// File: doc/BRIEF.md
# EDO DRAM Bus Timing Monitor

This block watches the strobe, write-enable and address lines of an EDO DRAM bus. It never drives them. Every input is registered on a monitor clock that runs much faster than the bus, so each pulse width is a count of monitor samples. A cycle is counted from one RAS fall to the following RAS rise. The monitor sorts every such cycle into one of seven kinds. It works this out from three things: whether CAS was already low when RAS fell, whether W was low at that fall, and how many CAS falls happen while RAS is low. After each cycle it reports the kind as a code with a one-clock strobe.

The monitor also applies a set of protocol timing rules. Each time a rule is broken, it sets a bit in a sticky violation vector and raises a violation pulse. Every limit is a sample count given by a parameter, so the same block can serve a slow test bus or a real-time bus. It is meant to be placed next to a memory controller in simulation or in on-chip debug logic. The violation vector then stays readable until the clear input resets it. No interface of this block carries a data stream, so there is no back-pressure: every input is sampled on every clock and every output is a plain registered level or pulse.

Top module: `dtm_monitor`

## Requirements
- R1: While reset is held and on the first clock after it, `cyc_valid`, `viol_pulse` and every bit of `viol_sticky` are 0.
- R2: `cyc_valid` is high for exactly one clock, two clocks after each sampled RAS rise that follows a sampled RAS fall, and `cyc_type` then carries a non-zero code: 1 read, 2 write, 3 EDO multi-column, 4 RAS-only refresh, 5 CAS-before-RAS refresh, 6 hidden refresh, 7 counter test.
- R3: If CAS is high when RAS falls and does not fall while RAS stays low, the cycle reports code 4.
- R4: If CAS is high when RAS falls and falls exactly once while RAS is low, the cycle reports code 1 when W was high at that CAS fall and code 2 when W was low. If CAS falls two or more times, it reports code 3, whatever the W levels.
- R5: If CAS is already low when RAS falls, the cycle reports code 5 when W is high at the RAS fall. When W is low at the RAS fall it reports code 7 and sets bit 6.
- R6: Suppose an access cycle with at least one column ends with CAS still low, and CAS stays low until RAS falls again. That next cycle reports code 6.
- R7: Bit 0 is set when RAS falls after being high for fewer than `RP_MIN` samples. This check starts only after the first RAS rise following reset.
- R8: Bit 1 is set when RAS rises after being low for fewer than `RAS_MIN` samples.
- R9: In an access cycle, each CAS fall after the first is checked twice. Bit 2 is set if CAS had been high for fewer than `CP_MIN` samples. Bit 3 is set if fewer than `PC_MIN` samples have passed since the previous CAS fall.
- R10: Bit 4 is set when RAS stays low for more than `RASP_MAX` samples. It fires once per low period.
- R11: Each row has an age in samples. An access or RAS-only cycle resets the age of the row latched at its RAS fall. Refresh cycles with CAS first (codes 5, 6 and 7) reset the age of the row chosen by an internal pointer, which then steps to the next row and wraps around. Bit 5 is set when any row's age passes `REF_MAX` samples.
- R12: A set violation bit stays set until `clr` is high on a clock edge; violations detected on that same edge are still recorded. For each clock in which one or more rules fire, `viol_pulse` is high for one clock, one clock after the detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears the sticky violation vector |
| ras_n | input | 1 | Observed row strobe, active low |
| cas_n | input | 1 | Observed column strobe, active low |
| we_n | input | 1 | Observed write enable, active low |
| addr | input | ROW_W | Observed multiplexed address; the row is taken at the RAS fall |
| cyc_valid | output | 1 | One-clock strobe per completed cycle |
| cyc_type | output | 3 | Cycle code, valid with `cyc_valid` |
| viol_sticky | output | 7 | Sticky rule bits (0 RAS precharge, 1 RAS width, 2 CAS precharge, 3 column period, 4 long RAS, 5 refresh late, 6 counter test) |
| viol_pulse | output | 1 | One-clock pulse after any rule fires |

## Verification
The bench builds the monitor with four tracked rows and shrunk limits: RAS high 10, RAS low 15, CAS high 3 and column period 7 samples, RAS low at most 60 samples, and row age at most 600 samples. With the long-RAS and refresh limits this short, both windows can be crossed in a few hundred clocks. Four rows let four CAS-first refreshes take the internal pointer through every row, so it is visible at the ports that a pointer-driven refresh counts toward every row's deadline, and each row's deadline can be shown to stay met right up to the point where it is then missed.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  typedef enum logic [2:0] {
    CT_NONE   = 3'd0,
    CT_READ   = 3'd1,
    CT_WRITE  = 3'd2,
    CT_EDO    = 3'd3,
    CT_ROR    = 3'd4,
    CT_CBR    = 3'd5,
    CT_HIDDEN = 3'd6,
    CT_CTEST  = 3'd7
  } cyc_type_e;

  typedef enum logic [1:0] {
    K_ACCESS,
    K_CBR,
    K_HIDDEN,
    K_CTEST
  } cyc_kind_e;

  localparam int NRULE   = 7;
  localparam int V_RP    = 0;
  localparam int V_RAS   = 1;
  localparam int V_CP    = 2;
  localparam int V_PC    = 3;
  localparam int V_RASP  = 4;
  localparam int V_REF   = 5;
  localparam int V_CTEST = 6;

endpackage

// File: rtl/dtm_sat_cnt.sv
module dtm_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= ONE;
    else if (cnt != '1)
      cnt <= cnt + ONE;
  end
endmodule

// File: rtl/dtm_classify.sv
module dtm_classify
  import dtm_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_fall,
  input  logic             cas_rise,
  input  logic             cas_act,
  input  logic             we_act,
  input  logic [ROW_W-1:0] row_in,
  output logic             cyc_valid,
  output logic [2:0]       cyc_type,
  output logic             ctest_hit,
  output logic             ref_evt,
  output logic             ref_ptr,
  output logic [ROW_W-1:0] ref_row,
  output logic             access_col
);
  cyc_kind_e        kind, kind_at_fall;
  cyc_type_e        t_now;
  logic             in_cyc, hold, first_wr;
  logic [1:0]       col_cnt;
  logic [ROW_W-1:0] row_lat;

  // Kind is fixed by the strobe order and W level at the RAS fall
  always_comb begin
    if (!cas_act)
      kind_at_fall = K_ACCESS;
    else if (we_act)
      kind_at_fall = K_CTEST;
    else if (hold)
      kind_at_fall = K_HIDDEN;
    else
      kind_at_fall = K_CBR;
  end

  always_comb begin
    case (kind)
      K_ACCESS: begin
        if (col_cnt == 2'd0)
          t_now = CT_ROR;
        else if (col_cnt == 2'd1)
          t_now = first_wr ? CT_WRITE : CT_READ;
        else
          t_now = CT_EDO;
      end
      K_CBR:    t_now = CT_CBR;
      K_HIDDEN: t_now = CT_HIDDEN;
      default:  t_now = CT_CTEST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cyc    <= 1'b0;
      kind      <= K_ACCESS;
      col_cnt   <= 2'd0;
      first_wr  <= 1'b0;
      row_lat   <= '0;
      cyc_valid <= 1'b0;
      cyc_type  <= CT_NONE;
    end else begin
      cyc_valid <= 1'b0;
      if (ras_fall) begin
        in_cyc   <= 1'b1;
        kind     <= kind_at_fall;
        col_cnt  <= 2'd0;
        first_wr <= 1'b0;
        row_lat  <= row_in;
      end else if (cas_fall && in_cyc && kind == K_ACCESS) begin
        if (col_cnt == 2'd0)
          first_wr <= we_act;
        if (col_cnt != 2'd2)
          col_cnt <= col_cnt + 2'd1;
      end
      if (ras_rise && in_cyc) begin
        cyc_valid <= 1'b1;
        cyc_type  <= t_now;
        in_cyc    <= 1'b0;
      end
    end
  end

  // CAS held low across a RAS rise after a column access arms hidden refresh
  always_ff @(posedge clk) begin
    if (!rst_n)
      hold <= 1'b0;
    else if (ras_rise && in_cyc)
      hold <= cas_act && ((kind == K_ACCESS && col_cnt != 2'd0) || kind == K_HIDDEN);
    else if (cas_rise)
      hold <= 1'b0;
  end

  assign ctest_hit  = ras_fall && cas_act && we_act;
  assign ref_evt    = ras_rise && in_cyc;
  assign ref_ptr    = (kind != K_ACCESS);
  assign ref_row    = row_lat;
  assign access_col = in_cyc && (kind == K_ACCESS) && (col_cnt != 2'd0);
endmodule

// File: rtl/dtm_refresh_track.sv
module dtm_refresh_track #(
  parameter int ROW_W   = 11,
  parameter int REF_MAX = 8000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             use_ptr,
  input  logic [ROW_W-1:0] row,
  output logic             late
);
  localparam int ROWS  = 1 << ROW_W;
  localparam int AGE_W = $clog2(REF_MAX + 2) + 1;
  localparam logic [AGE_W-1:0] LIMIT = AGE_W'(REF_MAX);
  localparam logic [AGE_W-1:0] ONE   = {{(AGE_W-1){1'b0}}, 1'b1};

  logic [ROW_W-1:0] ptr;
  logic [ROW_W-1:0] target;
  logic [ROWS-1:0]  late_vec;

  assign target = use_ptr ? ptr : row;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (evt && use_ptr)
      ptr <= ptr + {{(ROW_W-1){1'b0}}, 1'b1};
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [AGE_W-1:0] age;
    logic             hit;
    assign hit = evt && (target == ROW_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)
        age <= '0;
      else if (hit)
        age <= '0;
      else if (age != '1)
        age <= age + ONE;
    end
    assign late_vec[i] = !hit && (age == LIMIT);
  end

  assign late = |late_vec;
endmodule

// File: rtl/dtm_monitor.sv
module dtm_monitor
  import dtm_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int RP_MIN   = 10,
  parameter int RAS_MIN  = 15,
  parameter int CP_MIN   = 3,
  parameter int PC_MIN   = 7,
  parameter int RASP_MAX = 25000,
  parameter int REF_MAX  = 8000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [ROW_W-1:0] addr,
  output logic             cyc_valid,
  output logic [2:0]       cyc_type,
  output logic [NRULE-1:0] viol_sticky,
  output logic             viol_pulse
);
  localparam int MAXLIM = (RASP_MAX > RAS_MIN) ? RASP_MAX : RAS_MIN;
  localparam int MAXALL = (MAXLIM > RP_MIN + PC_MIN + CP_MIN) ? MAXLIM : RP_MIN + PC_MIN + CP_MIN;
  localparam int CW     = $clog2(MAXALL + 2) + 1;
  localparam logic [CW-1:0] L_RP   = CW'(RP_MIN);
  localparam logic [CW-1:0] L_RAS  = CW'(RAS_MIN);
  localparam logic [CW-1:0] L_CP   = CW'(CP_MIN);
  localparam logic [CW-1:0] L_PC   = CW'(PC_MIN);
  localparam logic [CW-1:0] L_RASP = CW'(RASP_MAX);

  logic             ras_q, ras_d, cas_q, cas_d, we_q;
  logic [ROW_W-1:0] addr_q;
  logic             ras_fall, ras_rise, cas_fall, cas_rise;
  logic [CW-1:0]    ras_cnt, cas_cnt, f2f_cnt;
  logic             primed;
  logic             ctest_hit, ref_evt, ref_ptr, access_col, ref_late;
  logic [ROW_W-1:0] ref_row;
  logic [NRULE-1:0] new_viol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      ras_d  <= 1'b1;
      cas_q  <= 1'b1;
      cas_d  <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
    end else begin
      ras_q  <= ras_n;
      ras_d  <= ras_q;
      cas_q  <= cas_n;
      cas_d  <= cas_q;
      we_q   <= we_n;
      addr_q <= addr;
    end
  end

  assign ras_fall = ras_d && !ras_q;
  assign ras_rise = !ras_d && ras_q;
  assign cas_fall = cas_d && !cas_q;
  assign cas_rise = !cas_d && cas_q;

  dtm_sat_cnt #(.W(CW)) u_ras_cnt (
    .clk(clk), .rst_n(rst_n), .restart(ras_fall || ras_rise), .cnt(ras_cnt)
  );
  dtm_sat_cnt #(.W(CW)) u_cas_cnt (
    .clk(clk), .rst_n(rst_n), .restart(cas_fall || cas_rise), .cnt(cas_cnt)
  );
  dtm_sat_cnt #(.W(CW)) u_f2f_cnt (
    .clk(clk), .rst_n(rst_n), .restart(cas_fall), .cnt(f2f_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      primed <= 1'b0;
    else if (ras_rise)
      primed <= 1'b1;
  end

  dtm_classify #(.ROW_W(ROW_W)) u_cls (
    .clk(clk), .rst_n(rst_n),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise),
    .cas_act(!cas_q), .we_act(!we_q), .row_in(addr_q),
    .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .ctest_hit(ctest_hit), .ref_evt(ref_evt), .ref_ptr(ref_ptr),
    .ref_row(ref_row), .access_col(access_col)
  );

  dtm_refresh_track #(.ROW_W(ROW_W), .REF_MAX(REF_MAX)) u_ref (
    .clk(clk), .rst_n(rst_n), .evt(ref_evt), .use_ptr(ref_ptr),
    .row(ref_row), .late(ref_late)
  );

  always_comb begin
    new_viol          = '0;
    new_viol[V_RP]    = ras_fall && primed && (ras_cnt < L_RP);
    new_viol[V_RAS]   = ras_rise && (ras_cnt < L_RAS);
    new_viol[V_CP]    = cas_fall && access_col && (cas_cnt < L_CP);
    new_viol[V_PC]    = cas_fall && access_col && (f2f_cnt < L_PC);
    new_viol[V_RASP]  = !ras_q && !ras_d && (ras_cnt == L_RASP);
    new_viol[V_REF]   = ref_late;
    new_viol[V_CTEST] = ctest_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_sticky <= '0;
      viol_pulse  <= 1'b0;
    end else begin
      viol_sticky <= (clr ? '0 : viol_sticky) | new_viol;
      viol_pulse  <= |new_viol;
    end
  end
endmodule

// File: rtl/dtm_monitor_chk.sv
module dtm_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       ras_q,
  input logic       ras_d,
  input logic       cyc_valid,
  input logic [2:0] cyc_type,
  input logic [6:0] viol_sticky,
  input logic       viol_pulse
);
  p_strobe_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> $past(ras_q && !ras_d));

  p_type_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_type != 3'd0));

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  p_pulse_sets_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (viol_sticky != 7'd0));

  p_sticky_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));
endmodule

bind dtm_monitor dtm_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ras_q(ras_q), .ras_d(ras_d),
  .cyc_valid(cyc_valid), .cyc_type(cyc_type),
  .viol_sticky(viol_sticky), .viol_pulse(viol_pulse)
);

// File: tb/sim_dtm_monitor.sv
module sim_dtm_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       cyc_valid, viol_pulse;
  logic [2:0] cyc_type;
  logic [6:0] viol_sticky;

  int checks = 0, errors = 0, nstrobe = 0, npulse = 0;
  logic [2:0] last_type = 3'd0, prev_type = 3'd0;
  bit done = 0;

  always #2 clk = ~clk;

  dtm_monitor #(
    .ROW_W(2), .RP_MIN(10), .RAS_MIN(15), .CP_MIN(3), .PC_MIN(7),
    .RASP_MAX(60), .REF_MAX(600)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .viol_sticky(viol_sticky), .viol_pulse(viol_pulse)
  );

  // Record outputs 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && cyc_valid) begin
      prev_type = last_type;
      last_type = cyc_type;
      nstrobe++;
    end
    if (rst_n && viol_pulse) npulse++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w, input logic [1:0] a, input int n);
    ras_n = r; cas_n = c; we_n = w; addr = a;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  function automatic logic [6:0] stk();
    return viol_sticky & 7'b101_1111;
  endfunction

  task automatic ror(input logic [1:0] row, input int lo);
    step(0, 1, 1, row, lo);
    step(1, 1, 1, 2'd0, 12);
  endtask

  task automatic cbr();
    step(1, 0, 1, 2'd0, 3);
    step(0, 0, 1, 2'd0, 16);
    step(1, 1, 1, 2'd0, 12);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", cyc_valid, 0);
    chk("R1 sticky in reset", viol_sticky, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse after reset", viol_pulse, 0);
    chk("R1 sticky after reset", viol_sticky, 0);
    step(1, 1, 1, 0, 12);
  endtask

  task automatic t_read();
    int s0;
    do_clr(); s0 = nstrobe;
    step(0, 1, 1, 1, 4); step(0, 0, 1, 1, 12); step(1, 1, 1, 0, 12);
    chk("R4 read code", last_type, 1);
    chk("R2 one strobe", nstrobe, s0 + 1);
    chk("R8 clean read", stk(), 0);
  endtask

  task automatic t_write();
    do_clr();
    step(0, 1, 1, 1, 4); step(0, 0, 0, 1, 12); step(1, 1, 1, 0, 12);
    chk("R4 write code", last_type, 2);
    chk("R4 clean write", stk(), 0);
  endtask

  task automatic t_edo();
    do_clr();
    step(0, 1, 1, 0, 4); step(0, 0, 1, 0, 4); step(0, 1, 1, 0, 4);
    step(0, 0, 0, 0, 4); step(0, 1, 1, 0, 4); step(0, 0, 1, 0, 4);
    step(1, 1, 1, 0, 12);
    chk("R4 edo code", last_type, 3);
    chk("R9 edo legal", stk(), 0);
  endtask

  task automatic t_edo_short();
    do_clr();
    step(0, 1, 1, 0, 4); step(0, 0, 1, 0, 4); step(0, 1, 1, 0, 2);
    step(0, 0, 1, 0, 4); step(0, 1, 1, 0, 4); step(1, 1, 1, 0, 12);
    chk("R9 cas high and period short", stk(), 7'b000_1100);
  endtask

  task automatic t_pc_only();
    do_clr();
    step(0, 1, 1, 0, 4); step(0, 0, 1, 0, 3); step(0, 1, 1, 0, 3);
    step(0, 0, 1, 0, 4); step(0, 1, 1, 0, 4); step(1, 1, 1, 0, 12);
    chk("R9 period only", stk(), 7'b000_1000);
  endtask

  task automatic t_ror();
    do_clr();
    ror(2'd2, 16);
    chk("R3 ras-only code", last_type, 4);
    chk("R3 clean", stk(), 0);
  endtask

  task automatic t_ras_short();
    do_clr();
    ror(2'd0, 10);
    chk("R8 ras low short", stk(), 7'b000_0010);
    chk("R3 short ras-only code", last_type, 4);
  endtask

  task automatic t_rp_short();
    do_clr();
    step(0, 1, 1, 0, 16); step(1, 1, 1, 0, 5);
    step(0, 1, 1, 0, 16); step(1, 1, 1, 0, 12);
    chk("R7 ras high short", stk(), 7'b000_0001);
  endtask

  task automatic t_cbr();
    do_clr();
    cbr();
    chk("R5 cbr code", last_type, 5);
    chk("R5 cbr clean", stk(), 0);
  endtask

  task automatic t_ctest();
    do_clr();
    step(1, 0, 0, 0, 3); step(0, 0, 0, 0, 16); step(1, 1, 1, 0, 12);
    chk("R5 counter test code", last_type, 7);
    chk("R5 counter test bit", stk(), 7'b100_0000);
  endtask

  task automatic t_hidden();
    int s0;
    do_clr(); s0 = nstrobe;
    step(0, 1, 1, 2, 4); step(0, 0, 1, 2, 12); step(1, 0, 1, 2, 12);
    step(0, 0, 1, 2, 16); step(1, 1, 1, 2, 12);
    chk("R6 leading read", prev_type, 1);
    chk("R6 hidden code", last_type, 6);
    chk("R6 two strobes", nstrobe, s0 + 2);
  endtask

  task automatic t_rasp();
    do_clr();
    ror(2'd3, 70);
    chk("R10 long ras", stk(), 7'b001_0000);
  endtask

  task automatic t_pulse_clear();
    int p0;
    for (int r = 0; r < 4; r++) ror(r[1:0], 16);
    do_clr(); p0 = npulse;
    ror(2'd1, 10);
    chk("R12 one pulse", npulse, p0 + 1);
    chk("R12 sticky full", viol_sticky, 7'b000_0010);
    ror(2'd1, 16);
    chk("R12 sticky kept", viol_sticky, 7'b000_0010);
    do_clr();
    chk("R12 cleared", viol_sticky, 0);
  endtask

  task automatic t_refresh();
    for (int r = 0; r < 4; r++) ror(r[1:0], 16);
    do_clr();
    step(1, 1, 1, 0, 300);
    for (int k = 0; k < 4; k++) cbr();
    step(1, 1, 1, 0, 400);
    chk("R11 pointer refresh keeps rows fresh", viol_sticky[5], 0);
    step(1, 1, 1, 0, 200);
    chk("R11 rows late", viol_sticky[5], 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_edo();
    t_edo_short();
    t_pc_only();
    t_ror();
    t_ras_short();
    t_rp_short();
    t_cbr();
    t_ctest();
    t_hidden();
    t_rasp();
    t_pulse_clear();
    t_refresh();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule